// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block is a single-word-line, direct-mapped cache that recovers part of the benefit of a two-way cache. The set array is split into a lower and an upper half. Every set has a partner set in the other half, and the partner's index is the set index with its top bit inverted. A request first looks at its own set. If that misses, a second lookup at the partner set follows before memory is involved. Each access therefore ends in one of three ways, each with its own latency: a fast hit, a slower pseudo-hit, or a miss that waits for a refill.

The processor side takes requests under a valid/ready handshake. `req_ready` is high only while the controller is idle, so a request is held off until the previous one has been answered. Responses come as a one-cycle `rsp_valid` pulse, and `rsp_kind` tells how the access was served. The processor cannot push back on responses. The memory side has a request port and a fill return. The memory answers a read request a fixed number of cycles later with a one-cycle `mem_fill_valid`. It takes writes without reply (write-through). A pseudo-hit exchanges the two partner lines, so a repeated access becomes a fast hit. A read miss installs the new word in the primary set and pushes the previous occupant into the partner set.

Top module: `pcache_pseudo_assoc`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and the first access to any address is reported as a miss.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the single `rsp_valid` pulse that answers it.
- R3: When the primary set holds the address, `rsp_kind` is 2'b01 (hit). `rsp_valid` is high in the first cycle after acceptance and returns the stored word.
- R4: The partner set is the primary index with its most significant bit inverted. A match there gives `rsp_kind` 2'b10 (pseudo-hit) in the second cycle after acceptance, never sooner.
- R5: On a pseudo-hit the primary and partner lines are exchanged. The next access to the same address is a hit, and the line that was in the primary set becomes reachable as a pseudo-hit.
- R6: A read miss issues exactly one memory read for the request address in the second cycle after acceptance. The response, kind 2'b11, comes in the cycle the fill returns and carries the fill word. With a refill latency of L cycles the miss takes 2+L cycles.
- R7: A read miss installs the new word in the primary set. A valid line previously there moves to the partner set, and the partner's old content is dropped.
- R8: Each stored tag includes the index MSB. A line displaced into a partner set never hits for an address whose own index is that set but whose upper address bits match the line.
- R9: Every write issues one memory write with the request address and data in its response cycle. A write hit updates the line. A write pseudo-hit swaps the lines and updates the new primary. A write miss allocates nothing and answers with kind 2'b11 in the second cycle.
- R10: `rsp_kind` is 2'b00 whenever `rsp_valid` is low and is never 2'b00 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 01 hit, 10 pseudo-hit, 11 miss, 00 idle |
| rsp_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_fill_valid | input | 1 | Refill word returned |
| mem_fill_data | input | DATA_W | Refill word |

## Verification
A stale or corrupted tag shows up at once as a wrong `rsp_kind` or a wrong latency. A missed or misdirected swap or eviction stays hidden until the same address, or its partner-set rival, is touched again. That access then returns a hit where a pseudo-hit was due, or the reverse, or a miss where a pseudo-hit was due. Wrong data in a line appears only on its next read. The random stream therefore keeps a handful of upper address values cycling over a few partner-set pairs, so that each line is revisited within a few accesses. A reference model predicts every outcome: kind, latency, data and memory traffic.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_HIT    = 2'b01,
    KIND_PSEUDO = 2'b10,
    KIND_MISS   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PRI  = 2'b01,
    ST_ALT  = 2'b10,
    ST_FILL = 2'b11
  } state_e;

endpackage

// File: rtl/pcache_store.sv
module pcache_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wa_en,
  input  logic              wa_valid,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data
);

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  // Port A always targets the primary set and port B its partner, so the
  // two never name the same set in one cycle.
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
        dat_q[s] <= '0;
      end else if (wa_en && (ra_idx == IDX_W'(s))) begin
        vld_q[s] <= wa_valid;
        tag_q[s] <= wa_tag;
        dat_q[s] <= wa_data;
      end else if (wb_en && (rb_idx == IDX_W'(s))) begin
        vld_q[s] <= wb_valid;
        tag_q[s] <= wb_tag;
        dat_q[s] <= wb_data;
      end
    end
  end

  assign ra_valid = vld_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_data  = dat_q[ra_idx];
  assign rb_valid = vld_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_data  = dat_q[rb_idx];

endmodule

// File: rtl/pcache_probe.sv
module pcache_probe #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              pri_valid,
  input  logic [TAG_W-1:0]  pri_tag,
  input  logic              alt_valid,
  input  logic [TAG_W-1:0]  alt_tag,
  output logic [IDX_W-1:0]  pri_idx,
  output logic [IDX_W-1:0]  alt_idx,
  output logic [TAG_W-1:0]  tag,
  output logic              pri_match,
  output logic              alt_match
);

  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  assign pri_idx   = addr[IDX_W-1:0];
  assign alt_idx   = pri_idx ^ FLIP;
  // The tag keeps the index MSB so a displaced line is told apart.
  assign tag       = addr[ADDR_W-1:IDX_W-1];
  assign pri_match = pri_valid && (pri_tag == tag);
  assign alt_match = alt_valid && (alt_tag == tag);

endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data,
  output logic [ADDR_W-1:0] cur_addr,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic              pri_match,
  input  logic              alt_match,
  input  logic              pri_valid,
  input  logic [TAG_W-1:0]  pri_tag,
  input  logic [DATA_W-1:0] pri_data,
  input  logic [TAG_W-1:0]  alt_tag,
  input  logic [DATA_W-1:0] alt_data,
  output logic              wa_en,
  output logic              wa_valid,
  output logic [TAG_W-1:0]  wa_tag,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data
);

  state_e            st_q, st_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  kind_e             kind;

  assign req_ready = (st_q == ST_IDLE);
  assign cur_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q <= st_d;
      if (req_valid && req_ready) begin
        wr_q   <= req_write;
        addr_q <= req_addr;
        wdat_q <= req_wdata;
      end
    end
  end

  always_comb begin
    st_d          = st_q;
    rsp_valid     = 1'b0;
    kind          = KIND_NONE;
    rsp_rdata     = '0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = addr_q;
    mem_req_wdata = wdat_q;
    wa_en         = 1'b0;
    wa_valid      = 1'b1;
    wa_tag        = cur_tag;
    wa_data       = wdat_q;
    wb_en         = 1'b0;
    wb_valid      = pri_valid;
    wb_tag        = pri_tag;
    wb_data       = pri_data;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_PRI;
      ST_PRI: begin
        if (pri_match) begin
          rsp_valid = 1'b1;
          kind      = KIND_HIT;
          rsp_rdata = pri_data;
          wa_en     = wr_q;
          st_d      = ST_IDLE;
        end else begin
          st_d = ST_ALT;
        end
      end
      ST_ALT: begin
        if (alt_match) begin
          // exchange partner lines, write data lands in the primary copy
          rsp_valid = 1'b1;
          kind      = KIND_PSEUDO;
          rsp_rdata = alt_data;
          wa_en     = 1'b1;
          wa_tag    = alt_tag;
          wa_data   = wr_q ? wdat_q : alt_data;
          wb_en     = 1'b1;
          st_d      = ST_IDLE;
        end else if (wr_q) begin
          rsp_valid = 1'b1;
          kind      = KIND_MISS;
          st_d      = ST_IDLE;
        end else begin
          mem_req_valid = 1'b1;
          st_d          = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_fill_valid) begin
          rsp_valid = 1'b1;
          kind      = KIND_MISS;
          rsp_rdata = mem_fill_data;
          wa_en     = 1'b1;
          wa_data   = mem_fill_data;
          wb_en     = pri_valid;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    // write-through: one memory write in the response cycle of every write
    if (rsp_valid && wr_q) begin
      mem_req_valid = 1'b1;
      mem_req_write = 1'b1;
    end
  end

  assign rsp_kind = kind;

endmodule

// File: rtl/pcache_pseudo_assoc.sv
module pcache_pseudo_assoc #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data
);

  localparam int TAG_W = ADDR_W - IDX_W + 1;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  pri_idx, alt_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              pri_match, alt_match;
  logic              pri_valid, alt_valid;
  logic [TAG_W-1:0]  pri_tag, alt_tag;
  logic [DATA_W-1:0] pri_data, alt_data;
  logic              wa_en, wa_valid, wb_en, wb_valid;
  logic [TAG_W-1:0]  wa_tag, wb_tag;
  logic [DATA_W-1:0] wa_data, wb_data;

  pcache_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_probe (
    .addr(cur_addr), .pri_valid(pri_valid), .pri_tag(pri_tag),
    .alt_valid(alt_valid), .alt_tag(alt_tag), .pri_idx(pri_idx),
    .alt_idx(alt_idx), .tag(cur_tag), .pri_match(pri_match),
    .alt_match(alt_match)
  );

  pcache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(pri_idx), .ra_valid(pri_valid), .ra_tag(pri_tag), .ra_data(pri_data),
    .rb_idx(alt_idx), .rb_valid(alt_valid), .rb_tag(alt_tag), .rb_data(alt_data),
    .wa_en(wa_en), .wa_valid(wa_valid), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  pcache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .cur_addr(cur_addr), .cur_tag(cur_tag),
    .pri_match(pri_match), .alt_match(alt_match),
    .pri_valid(pri_valid), .pri_tag(pri_tag), .pri_data(pri_data),
    .alt_tag(alt_tag), .alt_data(alt_data),
    .wa_en(wa_en), .wa_valid(wa_valid), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

endmodule

// File: rtl/pcache_pseudo_assoc_chk.sv
module pcache_pseudo_assoc_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic              mem_fill_valid,
  input logic [DATA_W-1:0] mem_fill_data
);

  // R2: no new request is taken while a response is being given
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3: a response in the cycle right after acceptance can only be a hit
  p_fast_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_valid || rsp_kind == 2'b01));

  // R4: a pseudo-hit is preceded by a busy cycle with no response
  p_pseudo_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b10) |-> ($past(!req_ready) && $past(!rsp_valid)));

  // R6: a memory read is never issued in a response cycle, and a returned
  // fill is answered at once as a miss with the fill word
  p_read_no_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> !rsp_valid);
  p_fill_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fill_valid |-> (rsp_valid && rsp_kind == 2'b11 && rsp_rdata == mem_fill_data));

  // R9: a memory write only appears in a response cycle
  p_wr_in_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> rsp_valid);

  // R10: the outcome code is non-zero exactly while a response is shown
  p_kind_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == (rsp_kind != 2'b00));

endmodule

bind pcache_pseudo_assoc pcache_pseudo_assoc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
);

// File: tb/pcache_pseudo_assoc_tb.sv
module pcache_pseudo_assoc_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W + 1;
  localparam int SETS   = 1 << IDX_W;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int LAT    = 5;
  localparam logic [1:0] K_HIT = 2'b01, K_PS = 2'b10, K_MISS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [1:0] rsp_kind;
  logic [DATA_W-1:0] rsp_rdata, mem_req_wdata, mem_fill_data;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_fill_valid;

  always #2.5 clk = ~clk;

  pcache_pseudo_assoc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
  );

  // fixed-latency memory
  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] pend_addr = '0;
  int unsigned       pend_cnt = 0;
  int                rd_issued = 0;

  assign mem_fill_valid = (pend_cnt == 1);
  assign mem_fill_data  = mem[pend_addr];

  always @(posedge clk) begin
    if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
    if (mem_req_valid && !mem_req_write) begin
      pend_addr <= mem_req_addr;
      pend_cnt  <= LAT;
      rd_issued <= rd_issued + 1;
    end
    if (mem_req_valid && mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
  end

  // reference model
  logic              m_v [SETS];
  logic [TAG_W-1:0]  m_t [SETS];
  logic [DATA_W-1:0] m_d [SETS];
  logic [DATA_W-1:0] shadow [WORDS];

  int checks = 0, errors = 0;

  function automatic logic [DATA_W-1:0] init_word(int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string tagname);
    logic [IDX_W-1:0] pi, ai;
    logic [TAG_W-1:0] tg;
    logic [1:0] ek;
    logic [DATA_W-1:0] ed;
    int el, lat, rd0;
    logic              sv; logic [TAG_W-1:0] st; logic [DATA_W-1:0] sd;
    pi = a[IDX_W-1:0];
    ai = pi ^ IDX_W'(1 << (IDX_W - 1));
    tg = a[ADDR_W-1:IDX_W-1];
    if (m_v[pi] && m_t[pi] == tg) begin
      ek = K_HIT; el = 1; ed = m_d[pi];
      if (w) m_d[pi] = d;
    end else if (m_v[ai] && m_t[ai] == tg) begin
      ek = K_PS; el = 2; ed = m_d[ai];
      sv = m_v[pi]; st = m_t[pi]; sd = m_d[pi];
      m_v[pi] = 1'b1; m_t[pi] = tg; m_d[pi] = w ? d : m_d[ai];
      m_v[ai] = sv; m_t[ai] = st; m_d[ai] = sd;
    end else if (w) begin
      ek = K_MISS; el = 2; ed = '0;
    end else begin
      ek = K_MISS; el = 2 + LAT; ed = shadow[a];
      if (m_v[pi]) begin
        m_v[ai] = 1'b1; m_t[ai] = m_t[pi]; m_d[ai] = m_d[pi];
      end
      m_v[pi] = 1'b1; m_t[pi] = tg; m_d[pi] = ed;
    end
    if (w) shadow[a] = d;

    rd0 = rd_issued;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      check({tagname, " R2 ready low while busy"}, 64'(req_ready), 64'd0);
      @(negedge clk);
      lat++;
    end
    check({tagname, " R2/R3/R4/R6 latency"}, 64'(lat), 64'(el));
    check({tagname, " R10 outcome kind"}, 64'(rsp_kind), 64'(ek));
    if (!w) begin
      check({tagname, " R3/R6 read data"}, 64'(rsp_rdata), 64'(ed));
      if (ek == K_MISS)
        check({tagname, " R6 one memory read"}, 64'(rd_issued - rd0), 64'd1);
    end else begin
      check({tagname, " R9 write-through"},
            {30'd0, mem_req_valid, mem_req_write, 22'd0, mem_req_addr},
            {30'd0, 1'b1, 1'b1, 22'd0, a});
      check({tagname, " R9 write data"}, 64'(mem_req_wdata), 64'(d));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [ADDR_W-1:0] a0, b0, c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = init_word(i);
      shadow[i] = init_word(i);
    end
    for (int s = 0; s < SETS; s++) begin
      m_v[s] = 1'b0; m_t[s] = '0; m_d[s] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset rsp", 64'(rsp_valid), 64'd0);
    check("R1 reset mem", 64'(mem_req_valid), 64'd0);
    check("R10 idle kind", 64'(rsp_kind), 64'd0);
    rst_n = 1'b1;

    // directed: A and B share a primary set (index 3), partner is 11
    a0 = {6'd5, 4'd3};
    b0 = {6'd9, 4'd3};
    c0 = {6'd5, 4'd11};         // same upper bits as A, A's partner set
    access(1'b0, a0, '0, "R1 cold miss");
    access(1'b0, a0, '0, "R3 repeat hit");
    access(1'b0, b0, '0, "R7 conflict miss");
    access(1'b0, a0, '0, "R4 pseudo");
    access(1'b0, a0, '0, "R5 swapped hit");
    access(1'b0, b0, '0, "R5 displaced pseudo");
    access(1'b0, c0, '0, "R8 partner alias miss");
    access(1'b0, b0, '0, "R7 evicted");
    access(1'b1, a0, 32'hCAFEF00D, "R9 write");
    access(1'b0, a0, '0, "R9 readback");
    access(1'b1, {6'd40, 4'd7}, 32'h1234_5678, "R9 write miss");
    access(1'b0, {6'd40, 4'd7}, '0, "R9 no alloc");

    // random: few upper values over two partner-set pairs
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] ra;
      logic [3:0] ix;
      ix = 4'($urandom_range(0, 3));
      ix = {ix[1], 2'b00, ix[0]};
      ra = {6'($urandom_range(0, 3)), ix};
      access(($urandom_range(0, 9) < 3), ra, $urandom, "R5 random");
    end
    finish_run();
  end

endmodule